// File: doc/BRIEF.md
# Single-Cell Lithium-Ion Protection Controller

This block is the digital core of a protector for one lithium-ion cell. Analog comparators outside it report, already synchronised to the clock, whether the cell is above the overvoltage level, below the charge-enable level, or below the undervoltage level. They also report the direction and size of the current, whether a charger is present, and how the pack pin sits against the supply. From these flags the controller decides when to turn off the charge FET, the discharge FET or both. It keeps a sticky flag for each fault and asks the power manager to sleep when the cell is depleted.

Every fault must be present for a number of consecutive cycles, set by its own parameter, before it trips. A single cycle without the condition starts the count over. Each fault is cleared by its own rule. An overvoltage fault clears when the cell drops below the charge-enable level or when discharge current flows. An undervoltage fault clears only when a charger is seen. The current faults are cleared by probing the pack pin with a test current whose direction the block selects. Monitoring happens only while the active-mode input is high; when it is low the state is frozen.

Top module: `cellprot_ctrl`

## Requirements
- R1: With `ov_cmp_i` high for OV_DLY+1 consecutive active cycles, flag bit 0 sets on that edge and `chg_off_o` goes high, while `dsg_off_o` stays low.
- R2: A set overvoltage flag clears on the edge after a cycle in which `ce_cmp_i` or `dsg_cmp_i` is high and no overvoltage trip qualifies.
- R3: With `uv_cmp_i` high for UV_DLY+1 consecutive active cycles, flag bit 1 sets and both FET outputs and `sleep_req_o` go high.
- R4: A set undervoltage flag clears only after a cycle with `chg_det_i` high, and no other input clears it.
- R5: With `occ_cmp_i` high for OC_DLY+1 cycles, flag bit 2 sets and both FETs turn off. The flag clears after a cycle in which `tst_pull_o` is 01 (pulldown) and `pack_hi_i` is low.
- R6: With `ocd_cmp_i` high for OC_DLY+1 cycles, flag bit 3 sets and only `dsg_off_o` goes high. The flag clears after a cycle in which `tst_pull_o` is 10 (pullup) and `pack_hi_i` is high.
- R7: With `sc_cmp_i` high for SC_DLY+1 cycles, flag bit 4 sets and only `dsg_off_o` goes high. It clears by the same pullup rule as R6.
- R8: A single cycle without a trip condition restarts that fault's count, so the full qualification run must be repeated.
- R9: `tst_pull_o` is 01 while the charge-overcurrent flag is set. Otherwise it is 10 while a discharge-overcurrent or short-circuit flag is set, and 00 when neither is set.
- R10: While `active_i` is low, no fault trips or clears and all outputs hold, and the qualification counts restart.
- R11: `chg_off_o` is the OR of flags 0–2 and `dsg_off_o` is the OR of flags 1–4. When a trip qualifies in the same cycle as that fault's release condition, the trip wins.
- R12: While reset is asserted, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| active_i | input | 1 | Active mode; monitoring enabled when high |
| ov_cmp_i | input | 1 | Cell above overvoltage level |
| ce_cmp_i | input | 1 | Cell below charge-enable level |
| dsg_cmp_i | input | 1 | Sense voltage shows discharge current |
| uv_cmp_i | input | 1 | Cell below undervoltage level |
| occ_cmp_i | input | 1 | Charge current above limit |
| ocd_cmp_i | input | 1 | Discharge current above limit |
| sc_cmp_i | input | 1 | Short-circuit level exceeded |
| chg_det_i | input | 1 | Pack pin above supply (charger present) |
| pack_hi_i | input | 1 | Pack pin above supply minus test threshold |
| chg_off_o | output | 1 | Charge FET disable |
| dsg_off_o | output | 1 | Discharge FET disable |
| flags_o | output | 5 | Sticky faults: bit0 OV, bit1 UV, bit2 charge OC, bit3 discharge OC, bit4 short |
| sleep_req_o | output | 1 | Sleep request after undervoltage |
| tst_pull_o | output | 2 | Test current: 00 none, 01 pulldown, 10 pullup |

## Verification
Trip qualification and release can fall in the same cycle. The bench brings an overvoltage count up to its terminal value and raises the charge-enable flag on the qualifying cycle; the flag must still set. The test-current arbitration can also meet two pending faults at once. The bench sets a charge-overcurrent flag and then trips a discharge overcurrent with the pack pin held high. It judges the outcome from `tst_pull_o` and the flags: pulldown holds and the discharge fault stays set until the charge fault has cleared. The bench then releases the two faults in that order.

// File: rtl/cellprot_pkg.sv
package cellprot_pkg;

    localparam int NFLT  = 5;
    localparam int F_OV  = 0;
    localparam int F_UV  = 1;
    localparam int F_OCC = 2;
    localparam int F_OCD = 3;
    localparam int F_SC  = 4;

    // Faults that force each FET off
    localparam logic [NFLT-1:0] CHG_MASK = 5'b00111;
    localparam logic [NFLT-1:0] DSG_MASK = 5'b11110;

    typedef enum logic [1:0] {
        PULL_NONE = 2'b00,
        PULL_DOWN = 2'b01,
        PULL_UP   = 2'b10
    } pull_e;

    typedef struct packed {
        logic [NFLT-1:0] flags;
        logic            chg_off;
        logic            dsg_off;
        pull_e           pull;
    } prot_st_t;

    // Charge overcurrent owns the probe first, pull-up faults wait
    function automatic pull_e pull_sel(input logic [NFLT-1:0] f);
        if (f[F_OCC])
            return PULL_DOWN;
        else if (f[F_OCD] || f[F_SC])
            return PULL_UP;
        else
            return PULL_NONE;
    endfunction

endpackage

// File: rtl/cellprot_qual_timer.sv
module cellprot_qual_timer #(
    parameter int unsigned DLY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic qual_o
);
    localparam int W = (DLY < 1) ? 1 : $clog2(DLY + 1);
    localparam logic [W-1:0] TERM = W'(DLY);

    logic [W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (!en_i)
            cnt_d = '0;
        else if (cnt_q != TERM)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    // Condition seen on DLY earlier edges and still present now
    assign qual_o = en_i && (cnt_q == TERM);

endmodule

// File: rtl/cellprot_release.sv
module cellprot_release
    import cellprot_pkg::*;
(
    input  pull_e           pull_q_i,
    input  logic            ce_cmp_i,
    input  logic            dsg_cmp_i,
    input  logic            chg_det_i,
    input  logic            pack_hi_i,
    output logic [NFLT-1:0] rel_o
);
    logic probe_down_ok;
    logic probe_up_ok;

    always_comb begin
        probe_down_ok = (pull_q_i == PULL_DOWN) && !pack_hi_i;
        probe_up_ok   = (pull_q_i == PULL_UP)   &&  pack_hi_i;

        rel_o        = '0;
        rel_o[F_OV]  = ce_cmp_i || dsg_cmp_i;
        rel_o[F_UV]  = chg_det_i;
        rel_o[F_OCC] = probe_down_ok;
        rel_o[F_OCD] = probe_up_ok;
        rel_o[F_SC]  = probe_up_ok;
    end

endmodule

// File: rtl/cellprot_ctrl.sv
module cellprot_ctrl
    import cellprot_pkg::*;
#(
    parameter int unsigned OV_DLY = 6,
    parameter int unsigned UV_DLY = 5,
    parameter int unsigned OC_DLY = 3,
    parameter int unsigned SC_DLY = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active_i,
    input  logic       ov_cmp_i,
    input  logic       ce_cmp_i,
    input  logic       dsg_cmp_i,
    input  logic       uv_cmp_i,
    input  logic       occ_cmp_i,
    input  logic       ocd_cmp_i,
    input  logic       sc_cmp_i,
    input  logic       chg_det_i,
    input  logic       pack_hi_i,
    output logic       chg_off_o,
    output logic       dsg_off_o,
    output logic [4:0] flags_o,
    output logic       sleep_req_o,
    output logic [1:0] tst_pull_o
);
    logic [NFLT-1:0] cond;
    logic [NFLT-1:0] qual;
    logic [NFLT-1:0] rel;
    prot_st_t        st_q, st_d;

    assign cond = {sc_cmp_i, ocd_cmp_i, occ_cmp_i, uv_cmp_i, ov_cmp_i};

    for (genvar g = 0; g < NFLT; g++) begin : g_qual
        localparam int unsigned D = (g == F_OV) ? OV_DLY :
                                    (g == F_UV) ? UV_DLY :
                                    (g == F_SC) ? SC_DLY : OC_DLY;
        cellprot_qual_timer #(
            .DLY (D)
        ) timer_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .en_i   (active_i && cond[g]),
            .qual_o (qual[g])
        );
    end

    cellprot_release rel_i (
        .pull_q_i  (st_q.pull),
        .ce_cmp_i  (ce_cmp_i),
        .dsg_cmp_i (dsg_cmp_i),
        .chg_det_i (chg_det_i),
        .pack_hi_i (pack_hi_i),
        .rel_o     (rel)
    );

    always_comb begin
        st_d = st_q;
        if (active_i) begin
            // a qualifying trip overrides a release in the same cycle
            st_d.flags   = qual | (st_q.flags & ~rel);
            st_d.chg_off = |(st_d.flags & CHG_MASK);
            st_d.dsg_off = |(st_d.flags & DSG_MASK);
            st_d.pull    = pull_sel(st_d.flags);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '{flags: '0, chg_off: 1'b0, dsg_off: 1'b0, pull: PULL_NONE};
        else
            st_q <= st_d;
    end

    assign chg_off_o   = st_q.chg_off;
    assign dsg_off_o   = st_q.dsg_off;
    assign flags_o     = st_q.flags;
    assign sleep_req_o = st_q.flags[F_UV];
    assign tst_pull_o  = st_q.pull;

endmodule

// File: rtl/cellprot_ctrl_chk.sv
module cellprot_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       active_i,
    input logic       ov_cmp_i,
    input logic       ce_cmp_i,
    input logic       dsg_cmp_i,
    input logic       uv_cmp_i,
    input logic       occ_cmp_i,
    input logic       ocd_cmp_i,
    input logic       sc_cmp_i,
    input logic       chg_det_i,
    input logic       pack_hi_i,
    input logic       chg_off_o,
    input logic       dsg_off_o,
    input logic [4:0] flags_o,
    input logic       sleep_req_o,
    input logic [1:0] tst_pull_o
);
    AST_OV_NEEDS_COND: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_o[0]) |-> $past(ov_cmp_i && active_i)); // R1

    AST_UV_CLR_CHARGER: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flags_o[1]) |-> $past(chg_det_i)); // R4

    AST_OCC_CLR_PROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flags_o[2]) |-> $past(tst_pull_o == 2'b01 && !pack_hi_i)); // R5

    AST_OCD_CLR_PROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flags_o[3]) |-> $past(tst_pull_o == 2'b10 && pack_hi_i)); // R6

    AST_PULL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tst_pull_o)); // R9

    AST_FROZEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!active_i) |-> $stable(flags_o)); // R10

    AST_DSG_OR: assert property (@(posedge clk) disable iff (!rst_n)
        dsg_off_o == (|flags_o[4:1])); // R11

    AST_CHG_OR: assert property (@(posedge clk) disable iff (!rst_n)
        chg_off_o == (|flags_o[2:0])); // R11

endmodule

bind cellprot_ctrl cellprot_ctrl_chk chk_i (.*);

// File: tb/cellprot_ctrl_tb_top.sv
module cellprot_ctrl_tb_top;
    localparam int OV_D = 6;
    localparam int UV_D = 5;
    localparam int OC_D = 3;
    localparam int SC_D = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic active = 1'b0;
    logic [4:0] cmp = '0;   // {sc, ocd, occ, uv, ov}
    logic ce = 1'b0, dsg = 1'b0, chg = 1'b0, pack_hi = 1'b0;
    logic chg_off, dsg_off, sleep_req;
    logic [4:0] flags;
    logic [1:0] pull;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cellprot_ctrl #(
        .OV_DLY (OV_D), .UV_DLY (UV_D), .OC_DLY (OC_D), .SC_DLY (SC_D)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .active_i (active),
        .ov_cmp_i (cmp[0]), .ce_cmp_i (ce), .dsg_cmp_i (dsg),
        .uv_cmp_i (cmp[1]), .occ_cmp_i (cmp[2]), .ocd_cmp_i (cmp[3]),
        .sc_cmp_i (cmp[4]), .chg_det_i (chg), .pack_hi_i (pack_hi),
        .chg_off_o (chg_off), .dsg_off_o (dsg_off), .flags_o (flags),
        .sleep_req_o (sleep_req), .tst_pull_o (pull)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cmp = '0; ce = 0; dsg = 0; chg = 0; pack_hi = 0; active = 1;
        step(2);
        rst_n = 1'b1;
    endtask

    function automatic int dly(input int f);
        case (f)
            0: return OV_D;
            1: return UV_D;
            4: return SC_D;
            default: return OC_D;
        endcase
    endfunction

    function automatic string rtag(input int f);
        case (f)
            0: return "R1";
            1: return "R3";
            2: return "R5";
            3: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check_state(input string req, input int f, input bit on);
        int exp_pull;
        exp_pull = !on ? 0 : (f == 2) ? 1 : (f >= 3) ? 2 : 0;
        chk(req, flags, on ? (1 << f) : 0);
        chk(req, chg_off, (on && f <= 2) ? 1 : 0);
        chk(req, dsg_off, (on && f >= 1) ? 1 : 0);
        chk(req, sleep_req, (on && f == 1) ? 1 : 0);
        chk(req, pull, exp_pull);
    endtask

    task automatic trip(input int f);
        cmp[f] = 1'b1;
        step(dly(f) + 1);
        cmp[f] = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual 0 expected 1 (run completed)");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R12: outputs during reset
        #1;
        step(1);
        chk("R12 flags", flags, 0);
        chk("R12 fets", {chg_off, dsg_off}, 0);
        chk("R12 sleep/pull", {sleep_req, pull}, 0);

        // Sweep run length for each fault (R1 R3 R5 R6 R7)
        for (int f = 0; f < 5; f++) begin
            for (int len = 1; len <= dly(f) + 3; len++) begin
                do_reset();
                pack_hi = (f == 2);
                cmp[f] = 1'b1;
                step(len);
                check_state(rtag(f), f, len >= dly(f) + 1);
                cmp[f] = 1'b0;
                step(2);
                check_state(rtag(f), f, len >= dly(f) + 1);
            end
        end

        // R8: gap restarts the count
        do_reset();
        cmp[0] = 1; step(OV_D); cmp[0] = 0; step(1);
        cmp[0] = 1; step(OV_D);
        chk("R8 no trip after split run", flags[0], 0);
        step(1);
        chk("R8 trip after full run", flags[0], 1);
        cmp[0] = 0;

        // R2: overvoltage release via charge-enable, then via discharge
        step(3);
        chk("R2 hold without release", flags[0], 1);
        ce = 1; step(1); ce = 0;
        chk("R2 clear on charge-enable", flags[0], 0);
        chk("R2 chg_off follows", chg_off, 0);
        trip(0);
        chk("R2 retrip", flags[0], 1);
        dsg = 1; step(1); dsg = 0;
        chk("R2 clear on discharge", flags[0], 0);

        // R4: undervoltage only clears on charger
        do_reset();
        trip(1);
        ce = 1; dsg = 1; pack_hi = 1; step(3);
        chk("R4 ignores other releases", flags[1], 1);
        chk("R4 sleep held", sleep_req, 1);
        ce = 0; dsg = 0; pack_hi = 0;
        chg = 1; step(1); chg = 0;
        chk("R4 clear on charger", flags[1], 0);
        chk("R4 sleep drops", sleep_req, 0);

        // R5: charge overcurrent probe release
        do_reset();
        pack_hi = 1; trip(2);
        chk("R5 pulldown", pull, 1);
        step(2);
        chk("R5 held while pack high", flags[2], 1);
        pack_hi = 0; step(1);
        chk("R5 clear", flags[2], 0);
        chk("R5 fets on", {chg_off, dsg_off}, 0);

        // R6 / R7: pull-up release
        for (int f = 3; f < 5; f++) begin
            do_reset();
            trip(f);
            chk(rtag(f), pull, 2);
            step(2);
            chk(rtag(f), flags[f], 1);
            pack_hi = 1; step(1);
            chk(rtag(f), flags[f], 0);
            chk(rtag(f), pull, 0);
        end

        // R9: arbitration between pulldown and pullup faults
        do_reset();
        pack_hi = 1; trip(2);
        trip(3);
        chk("R9 both set", flags[3:2], 3);
        chk("R9 pulldown first", pull, 1);
        pack_hi = 0; step(1);
        chk("R9 occ cleared", flags[3:2], 2);
        chk("R9 pullup next", pull, 2);
        step(2);
        chk("R9 ocd held while low", flags[3], 1);
        pack_hi = 1; step(1);
        chk("R9 ocd cleared", flags, 0);
        chk("R9 no pull", pull, 0);

        // R10: inactive freezes everything
        do_reset();
        active = 0; cmp = 5'b00011; step(OV_D + UV_D + 4);
        chk("R10 no trip idle", flags, 0);
        active = 1; step(1);
        chk("R10 count restarted", flags, 0);
        cmp = 0;
        trip(1);
        active = 0; chg = 1; step(3);
        chk("R10 no release idle", flags[1], 1);
        chk("R10 outputs held", {chg_off, dsg_off, sleep_req}, 3'b111);
        active = 1; step(1); chg = 0;
        chk("R10 release when active", flags[1], 0);

        // R11: trip beats release in the same cycle
        do_reset();
        cmp[0] = 1; step(OV_D);
        ce = 1; step(1);
        chk("R11 trip wins", flags[0], 1);
        chk("R11 chg_off", chg_off, 1);
        chk("R11 dsg_off", dsg_off, 0);
        cmp[0] = 0; step(1); ce = 0;
        chk("R11 then releases", flags[0], 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule